// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block guards the mode controls of an embedded flash array. Software writes a small set of control and block-select registers over a simple register bus. The controller decides, on every clock, which flash mode may be presented to the array: idle, program, erase, program-verify or erase-verify. It also drives a per-block erase select vector to the array.

Three protections gate program and erase. The first is a global software enable bit. The second is a per-block erase mask split over two registers. The third is an emulation input that, while high, blocks both program and erase on every block. A sticky error latch watches for illegal processor activity while a program or erase is running: a flash read, entry into exception handling, or a sleep. On any of these it aborts the operation at once. Verify modes remain usable after that, and only a power-on reset clears the latch.

The mode is registered. A register write or an error event takes effect on the mode output at the same clock edge that updates the registers.

Top module: `flash_pe_guard`

## Requirements
- R1: After power-on reset (`por_n` low), all registers read 0, `mode_o` is 0 (idle), `err_o` is 0 and `erase_blk_o` is 0.
- R2: Control register (address 0) bits are: bit0 software enable, bit1 program request, bit2 erase request, bit3 program-verify request, bit4 erase-verify request. While bit0 is 0, setting bit1 or bit2 leaves `mode_o` out of program (1) and erase (2), although the bits read back as written.
- R3: With software enable set, emulation low, error clear and only the program request set, `mode_o` becomes 1 at the edge that writes the register, and `erase_blk_o` stays 0.
- R4: Block select registers hold one erase-enable bit per block: address 2 bits 7..0 hold blocks 7..0, and address 3 bits 3..0 hold blocks 11..8. Bits of address 3 above the last block read 0. In erase mode (`mode_o`=2), `erase_blk_o` equals the block mask; in every other mode it is 0.
- R5: When both block-select registers are all zeros, an erase request does not enter erase mode.
- R6: While `emu_en_i` is 1, neither program nor erase mode is entered. When it falls with requests still set, the permitted mode resumes at the next edge.
- R7: If program and erase are requested together, neither mode is entered.
- R8: A flash read, exception entry or sleep seen at an edge while `mode_o` is 1 or 2 sets `err_o` and removes program/erase mode at that same edge. The same events in any other mode have no effect.
- R9: An error leaves the control and block-select register contents unchanged.
- R10: While `err_o` is 1, program and erase are never entered, but program-verify (`mode_o`=3) and erase-verify (`mode_o`=4) are still entered from their request bits.
- R11: No register write clears `err_o`. Its status bit reads at address 1 bit 0, that register ignores writes, and only `por_n` clears it.
- R12: Verify modes need software enable. Program-verify alone gives 3, erase-verify alone gives 4, both together give 0. A granted program or erase takes precedence over a verify request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status, 2 block low, 3 block high) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| emu_en_i | input | 1 | Emulation active: protects all blocks |
| flash_rd_i | input | 1 | Processor read of the flash (data, fetch or vector) |
| exc_entry_i | input | 1 | Exception handling entered (non-reset) |
| sleep_i | input | 1 | Sleep instruction executed |
| mode_o | output | 3 | Current flash mode: 0 idle, 1 program, 2 erase, 3 program-verify, 4 erase-verify |
| err_o | output | 1 | Sticky error-protection flag |
| erase_blk_o | output | 12 | Per-block erase select to the array |

## Verification
The bench builds the block with its default of twelve blocks. The block-select mask therefore spans a full low register and a partial high register, which exercises both the bit mapping across the two registers and the zero readback of unused high bits. A behavioural model predicts the mode, error flag, erase vector and readback after every edge. Scenarios step through every protection alone and in combination, the three error sources in both program and erase, and recovery by power-on reset.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE  = 3'd0,
        MODE_PROG  = 3'd1,
        MODE_ERASE = 3'd2,
        MODE_PVFY  = 3'd3,
        MODE_EVFY  = 3'd4
    } fmode_e;

    // First field is the most significant bit: sw_en lands on bit 0.
    typedef struct packed {
        logic ev_req;
        logic pv_req;
        logic er_req;
        logic pg_req;
        logic sw_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_BLO  = 2'd2;
    localparam logic [1:0] ADDR_BHI  = 2'd3;

endpackage

// File: rtl/flash_pe_regs.sv
module flash_pe_regs
    import flash_pe_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int LO_W       = 8,
    parameter int DATA_W     = 8
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  we,
    input  logic [1:0]            addr,
    input  logic [DATA_W-1:0]     wdata,
    output ctrl_t                 ctrl_q,
    output ctrl_t                 ctrl_nx,
    output logic [NUM_BLOCKS-1:0] blk_q,
    output logic [NUM_BLOCKS-1:0] blk_nx
);
    localparam int HI_W = NUM_BLOCKS - LO_W;

    typedef struct packed {
        ctrl_t                 ctrl;
        logic [NUM_BLOCKS-1:0] blk;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            case (addr)
                ADDR_CTRL: st_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
                ADDR_BLO:  st_d.blk[LO_W-1:0] = wdata[LO_W-1:0];
                ADDR_BHI:  st_d.blk[NUM_BLOCKS-1:LO_W] = wdata[HI_W-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_q  = st_q.ctrl;
    assign ctrl_nx = st_d.ctrl;
    assign blk_q   = st_q.blk;
    assign blk_nx  = st_d.blk;

    // R11: the status address never changes stored contents
    a_r11_stat_write_inert: assert property (@(posedge clk) disable iff (!por_n)
        (we && addr == ADDR_STAT) |=> (st_q == $past(st_q)));

endmodule

// File: rtl/flash_pe_err.sv
module flash_pe_err (
    input  logic clk,
    input  logic por_n,
    input  logic pe_active,
    input  logic flash_rd,
    input  logic exc_entry,
    input  logic sleep_ev,
    output logic err_nx,
    output logic err_q
);
    logic err_d;

    always_comb begin
        err_d = err_q;
        if (pe_active && (flash_rd || exc_entry || sleep_ev))
            err_d = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign err_nx = err_d;

    // R11: once set, the flag holds until power-on reset
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!por_n)
        err_q |=> err_q);

    // R8: the flag only rises from an event during program or erase
    a_r8_err_cause: assert property (@(posedge clk) disable iff (!por_n)
        (!err_q && !(pe_active && (flash_rd || exc_entry || sleep_ev))) |=> !err_q);

endmodule

// File: rtl/flash_pe_arb.sv
module flash_pe_arb
    import flash_pe_pkg::*;
#(
    parameter int NUM_BLOCKS = 12
) (
    input  ctrl_t                 ctrl,
    input  logic [NUM_BLOCKS-1:0] blk,
    input  logic                  err,
    input  logic                  emu,
    output fmode_e                mode
);
    logic pe_ok;

    always_comb begin
        pe_ok = ctrl.sw_en && !emu && !err;
        mode  = MODE_IDLE;
        if (pe_ok && ctrl.pg_req && !ctrl.er_req)
            mode = MODE_PROG;
        else if (pe_ok && ctrl.er_req && !ctrl.pg_req && (|blk))
            mode = MODE_ERASE;
        else if (ctrl.sw_en && ctrl.pv_req && !ctrl.ev_req)
            mode = MODE_PVFY;
        else if (ctrl.sw_en && ctrl.ev_req && !ctrl.pv_req)
            mode = MODE_EVFY;
    end

endmodule

// File: rtl/flash_pe_guard.sv
module flash_pe_guard
    import flash_pe_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int LO_W       = 8,
    parameter int DATA_W     = 8
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  reg_we,
    input  logic [1:0]            reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  emu_en_i,
    input  logic                  flash_rd_i,
    input  logic                  exc_entry_i,
    input  logic                  sleep_i,
    output logic [2:0]            mode_o,
    output logic                  err_o,
    output logic [NUM_BLOCKS-1:0] erase_blk_o
);
    localparam int HI_W = NUM_BLOCKS - LO_W;

    ctrl_t                 ctrl_q, ctrl_nx;
    logic [NUM_BLOCKS-1:0] blk_q, blk_nx;
    logic                  err_q, err_nx;
    fmode_e                mode_d, mode_q;
    logic                  pe_active;

    assign pe_active = (mode_q == MODE_PROG) || (mode_q == MODE_ERASE);

    flash_pe_regs #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .LO_W      (LO_W),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk    (clk),
        .por_n  (por_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .ctrl_q (ctrl_q),
        .ctrl_nx(ctrl_nx),
        .blk_q  (blk_q),
        .blk_nx (blk_nx)
    );

    flash_pe_err u_err (
        .clk      (clk),
        .por_n    (por_n),
        .pe_active(pe_active),
        .flash_rd (flash_rd_i),
        .exc_entry(exc_entry_i),
        .sleep_ev (sleep_i),
        .err_nx   (err_nx),
        .err_q    (err_q)
    );

    flash_pe_arb #(
        .NUM_BLOCKS(NUM_BLOCKS)
    ) u_arb (
        .ctrl(ctrl_nx),
        .blk (blk_nx),
        .err (err_nx),
        .emu (emu_en_i),
        .mode(mode_d)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) mode_q <= MODE_IDLE;
        else        mode_q <= mode_d;
    end

    logic [DATA_W-1:0] hi_rd;

    always_comb begin
        hi_rd = '0;
        hi_rd[HI_W-1:0] = blk_q[NUM_BLOCKS-1:LO_W];
        case (reg_addr)
            ADDR_CTRL: reg_rdata = DATA_W'(ctrl_q);
            ADDR_STAT: reg_rdata = DATA_W'(err_q);
            ADDR_BLO:  reg_rdata = blk_q[LO_W-1:0];
            default:   reg_rdata = hi_rd;
        endcase
    end

    assign mode_o      = mode_q;
    assign err_o       = err_q;
    assign erase_blk_o = (mode_q == MODE_ERASE) ? blk_q : '0;

    // R2: program or erase only with the software enable stored
    a_r2_pe_needs_enable: assert property (@(posedge clk) disable iff (!por_n)
        pe_active |-> ctrl_q.sw_en);

    // R5: erase never runs with an empty block mask
    a_r5_erase_needs_mask: assert property (@(posedge clk) disable iff (!por_n)
        (mode_q == MODE_ERASE) |-> (|blk_q));

    // R6: emulation at an edge keeps program and erase off after it
    a_r6_emu_blocks: assert property (@(posedge clk) disable iff (!por_n)
        emu_en_i |=> !pe_active);

    // R7: program and erase requests together grant neither
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!por_n)
        (ctrl_q.pg_req && ctrl_q.er_req) |-> !pe_active);

    // R8: an error aborts program or erase at the edge that raises it
    a_r8_abort: assert property (@(posedge clk) disable iff (!por_n)
        $rose(err_q) |-> !pe_active);

    // R10: no program or erase while the error flag stands
    a_r10_locked: assert property (@(posedge clk) disable iff (!por_n)
        err_q |-> !pe_active);

    // R4: block select reaches the array only in erase
    a_r4_blk_gate: assert property (@(posedge clk) disable iff (!por_n)
        (mode_q != MODE_ERASE) |-> (erase_blk_o == '0));

endmodule

// File: tb/flash_pe_guard_bench.sv
module flash_pe_guard_bench;
    localparam int NB = 12;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [7:0]    reg_wdata = 8'd0;
    logic [7:0]    reg_rdata;
    logic          emu_en_i = 1'b0;
    logic          flash_rd_i = 1'b0;
    logic          exc_entry_i = 1'b0;
    logic          sleep_i = 1'b0;
    logic [2:0]    mode_o;
    logic          err_o;
    logic [NB-1:0] erase_blk_o;

    flash_pe_guard #(.NUM_BLOCKS(NB)) u_flash_pe_guard (
        .clk(clk), .por_n(por_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .emu_en_i(emu_en_i),
        .flash_rd_i(flash_rd_i), .exc_entry_i(exc_entry_i), .sleep_i(sleep_i),
        .mode_o(mode_o), .err_o(err_o), .erase_blk_o(erase_blk_o)
    );

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string tag = "R1";

    // behavioural model state
    int m_ctrl = 0;
    int m_blk  = 0;
    int m_err  = 0;
    int m_mode = 0;

    function automatic int pick_mode();
        int ok, sw, pg, er, pv, evr;
        sw  = m_ctrl & 1;
        pg  = (m_ctrl >> 1) & 1;
        er  = (m_ctrl >> 2) & 1;
        pv  = (m_ctrl >> 3) & 1;
        evr = (m_ctrl >> 4) & 1;
        ok  = (sw == 1 && !emu_en_i && m_err == 0) ? 1 : 0;
        if (ok == 1 && pg == 1 && er == 0) return 1;
        if (ok == 1 && er == 1 && pg == 0 && m_blk != 0) return 2;
        if (sw == 1 && pv == 1 && evr == 0) return 3;
        if (sw == 1 && evr == 1 && pv == 0) return 4;
        return 0;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_rd();
        case (reg_addr)
            2'd0: return m_ctrl;
            2'd1: return m_err;
            2'd2: return m_blk & 8'hFF;
            default: return (m_blk >> 8) & 4'hF;
        endcase
    endfunction

    task automatic compare();
        check(tag, "mode", int'(mode_o), m_mode);
        check(tag, "err", int'(err_o), m_err);
        check(tag, "erase_blk", int'(erase_blk_o), (m_mode == 2) ? m_blk : 0);
        check(tag, "rdata", int'(reg_rdata), exp_rd());
    endtask

    task automatic tick();
        int ev;
        @(posedge clk);
        ev = ((m_mode == 1 || m_mode == 2) && (flash_rd_i || exc_entry_i || sleep_i)) ? 1 : 0;
        if (reg_we) begin
            case (reg_addr)
                2'd0: m_ctrl = int'(reg_wdata) & 8'h1F;
                2'd2: m_blk = (m_blk & 12'hF00) | int'(reg_wdata);
                2'd3: m_blk = (m_blk & 12'h0FF) | ((int'(reg_wdata) & 4'hF) << 8);
                default: ;
            endcase
        end
        if (ev == 1) m_err = 1;
        m_mode = pick_mode();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, input string req, input int exp);
        reg_addr = a;
        #1;
        check(req, "readback", int'(reg_rdata), exp);
    endtask

    task automatic por();
        @(negedge clk);
        por_n = 1'b0;
        m_ctrl = 0; m_blk = 0; m_err = 0; m_mode = 0;
        #2;
        @(negedge clk);
        por_n = 1'b1;
        tag = "R1";
        compare();
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        tag = "R1";
        compare();
        peek(2'd0, "R1", 0); peek(2'd2, "R1", 0); peek(2'd3, "R1", 0);

        tag = "R2";
        wr(2'd0, 8'h02); tick(); peek(2'd0, "R2", 2);
        wr(2'd0, 8'h04); tick();

        tag = "R3";
        wr(2'd0, 8'h03); tick(); tick();

        tag = "R7";
        wr(2'd0, 8'h07); tick();

        tag = "R5";
        wr(2'd0, 8'h05); tick();

        tag = "R4";
        wr(2'd2, 8'hA5); wr(2'd3, 8'hFF); tick();
        peek(2'd3, "R4", 8'h0F); peek(2'd2, "R4", 8'hA5);
        wr(2'd2, 8'h00); tick(); wr(2'd3, 8'h00);
        wr(2'd2, 8'h01); tick();

        tag = "R6";
        emu_en_i = 1'b1; tick(); tick();
        wr(2'd0, 8'h03); tick();
        emu_en_i = 1'b0; tick();
        wr(2'd0, 8'h05); tick();

        tag = "R12";
        wr(2'd0, 8'h09); wr(2'd0, 8'h11); wr(2'd0, 8'h19);
        wr(2'd0, 8'h08); wr(2'd0, 8'h0B); wr(2'd0, 8'h15); tick();

        tag = "R8";
        wr(2'd0, 8'h09);
        flash_rd_i = 1'b1; exc_entry_i = 1'b1; sleep_i = 1'b1; tick();
        flash_rd_i = 1'b0; exc_entry_i = 1'b0; sleep_i = 1'b0; tick();
        wr(2'd0, 8'h03); tick();
        flash_rd_i = 1'b1; tick(); flash_rd_i = 1'b0; tick();

        tag = "R9";
        peek(2'd0, "R9", 3); peek(2'd2, "R9", 1); peek(2'd3, "R9", 0);

        tag = "R10";
        wr(2'd0, 8'h03); tick(); wr(2'd0, 8'h05);
        wr(2'd0, 8'h09); wr(2'd0, 8'h11); tick();

        tag = "R11";
        wr(2'd1, 8'h00); tick(); peek(2'd1, "R11", 1);
        wr(2'd0, 8'h00); wr(2'd2, 8'h00); peek(2'd1, "R11", 1);
        por(); peek(2'd1, "R11", 0);

        tag = "R8";
        wr(2'd3, 8'h04); wr(2'd0, 8'h05); tick();
        exc_entry_i = 1'b1; tick(); exc_entry_i = 1'b0; tick();
        tag = "R9";
        peek(2'd3, "R9", 4); peek(2'd0, "R9", 5);
        por();

        tag = "R8";
        wr(2'd0, 8'h03);
        sleep_i = 1'b1; tick(); sleep_i = 1'b0; tick();
        tag = "R10";
        wr(2'd0, 8'h0B); tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) cycles++;
endmodule